// File: doc/BRIEF.md
# Masked Time-of-Day Alarm with Interrupt Flags

This block watches the running calendar time and raises an alarm flag when the time matches a set of programmed alarm bytes. It also holds two more event flags, one set by an external wake event and one set by a watchdog expiry. Each flag has its own enable bit, and any enabled flag drives a single active-low interrupt line. A host reaches the alarm bytes, the enable byte and the flag byte through a small synchronous register port.

The top bit of each of the four alarm bytes is a mask bit. Together the four mask bits set how coarse the match is: every second, or seconds only, or minutes and seconds, or the full time of day, or the full time of day plus a calendar day. Bit 6 of the fourth alarm byte chooses whether that calendar day is the date of the month or the day of the week. A mask pattern outside the supported set falls back to an alarm on every second, so that a bad setting is easy to notice. The alarm compare runs only on the one-second update strobe. Reading the flag byte clears the event flags when the read access ends. The flags do not clear while the read is still in progress.

Top module: `alrm_irq_unit`

## Requirements
- R1: On a `tick_i` cycle, the mask nibble {bit7 of byte 3, byte 2, byte 1, byte 0} selects the match. 1111 matches every tick. 1110 matches when seconds are equal. 1100 matches when minutes and seconds are equal. 1000 matches when hours, minutes and seconds are equal. 0000 matches when the calendar day, hours, minutes and seconds are equal. A match sets the alarm flag (flag byte bit 3) at the next clock edge.
- R2: A mask nibble other than the five listed in R1 sets the alarm flag on every tick, whatever the time inputs hold.
- R3: With mask 0000, bit 6 of alarm byte 3 picks the calendar input. A value of 0 compares bits 5:0 with `time_mday_i`. A value of 1 compares them with `time_wday_i`.
- R4: The alarm flag is never set in a cycle where `tick_i` is low, even if the time matches.
- R5: A `kick_i` pulse sets the wake flag (flag byte bit 2). A write to the flag byte (address 4) loads bit 2 of the write data into this flag, so 1 sets it and 0 clears it.
- R6: A `wdog_i` pulse sets the watchdog flag (flag byte bit 1). When the flag byte is written, a 0 in bit 3 or bit 1 clears the alarm or watchdog flag. A 1 in those bits leaves the flag as it was.
- R7: The enable byte is at address 5, with bit 2 for alarm, bit 1 for wake and bit 0 for watchdog. Flag byte bit 0 reads 1 when any flag is set together with its enable, and `irq_n_o` is low exactly then.
- R8: A read of the flag byte leaves the flags unchanged while the read lasts. When the read ends, either because the select drops or because the address moves away, the alarm, wake and watchdog flags clear at the next edge.
- R9: A flag event (match, kick or watchdog) that arrives in the same cycle as the end-of-read clear wins, and that flag stays set.
- R10: After reset, all flags and enables are 0 and `irq_n_o` is high. Flag byte bits 7:4 always read 0, and writing to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_sec_i | input | 8 | Current seconds, BCD |
| time_min_i | input | 8 | Current minutes, BCD |
| time_hour_i | input | 8 | Current hours, BCD, 24-hour |
| time_wday_i | input | 8 | Current day of week |
| time_mday_i | input | 8 | Current date of month, BCD |
| tick_i | input | 1 | One-second update strobe, one cycle wide |
| kick_i | input | 1 | Wake event pulse |
| wdog_i | input | 1 | Watchdog expiry pulse |
| bus_sel_i | input | 1 | Register access active |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address: 0 to 3 alarm bytes, 4 flags, 5 enables |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data. It is valid during a read and 0 otherwise |
| flags_o | output | 8 | Live flag byte |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The in-RTL assertions check the following on every cycle:
- The alarm flag only rises after an update strobe.
- A wake pulse or a watchdog pulse is always recorded.
- No flag falls while a flag read is still in progress.
- An event arriving with the end-of-read clear survives it.
- The interrupt line agrees with the enabled flags.

Whether each mask pattern matches the right fields, the day/date choice, and the write-one/write-zero rules on each flag depend on specific stored values and times. Only the bench's vector table and directed scenarios can show these.

// File: rtl/alrm_pkg.sv
package alrm_pkg;

   typedef enum logic [2:0] {
      MATCH_ANY,
      MATCH_S,
      MATCH_MS,
      MATCH_HMS,
      MATCH_ALL
   } alrm_mode_e;

   localparam int N_FIELDS = 4;

   // flag byte positions (bit order is part of the interface)
   localparam int FLG_TDF = 3;
   localparam int FLG_KSF = 2;
   localparam int FLG_WDF = 1;
   localparam int FLG_IRQ = 0;

   // enable byte positions
   localparam int EN_TIE = 2;
   localparam int EN_KIE = 1;
   localparam int EN_WDE = 0;
   localparam int EN_W   = 3;

   // significant value bits per compared field: sec, min, hour, day/date
   function automatic int field_bits(input int idx);
      case (idx)
         0, 1:    return 7;
         default: return 6;
      endcase
   endfunction

   function automatic alrm_mode_e decode_mask(input logic [3:0] m);
      case (m)
         4'b1111: return MATCH_ANY;
         4'b1110: return MATCH_S;
         4'b1100: return MATCH_MS;
         4'b1000: return MATCH_HMS;
         4'b0000: return MATCH_ALL;
         default: return MATCH_ANY;
      endcase
   endfunction

endpackage

// File: rtl/alrm_match.sv
module alrm_match
   import alrm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [N_FIELDS-1:0][BYTE_W-1:0] alm_i,
   input  logic [BYTE_W-1:0]               t_sec_i,
   input  logic [BYTE_W-1:0]               t_min_i,
   input  logic [BYTE_W-1:0]               t_hour_i,
   input  logic [BYTE_W-1:0]               t_wday_i,
   input  logic [BYTE_W-1:0]               t_mday_i,
   input  logic                            tick_i,
   output logic                            hit_o
);

   localparam int MASK_BIT = BYTE_W - 1;
   localparam int DSEL_BIT = BYTE_W - 2;

   if (BYTE_W < 8) begin : g_bad_width
      $error("alrm_match: BYTE_W must be at least 8");
   end

   logic [3:0]               mask;
   alrm_mode_e               mode;
   logic [BYTE_W-1:0]        t_cal;
   logic [BYTE_W-1:0]        t_fld [N_FIELDS];
   logic [N_FIELDS-1:0]      eq;
   logic                     fld_ok;

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_mask
      assign mask[g] = alm_i[g][MASK_BIT];
   end

   assign mode  = decode_mask(mask);
   assign t_cal = alm_i[3][DSEL_BIT] ? t_wday_i : t_mday_i;

   assign t_fld[0] = t_sec_i;
   assign t_fld[1] = t_min_i;
   assign t_fld[2] = t_hour_i;
   assign t_fld[3] = t_cal;

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_cmp
      localparam logic [BYTE_W-1:0] KEEP =
         BYTE_W'((64'd1 << field_bits(g)) - 64'd1);
      assign eq[g] = ((alm_i[g] ^ t_fld[g]) & KEEP) == '0;
   end

   always_comb begin
      case (mode)
         MATCH_S:   fld_ok = eq[0];
         MATCH_MS:  fld_ok = eq[0] & eq[1];
         MATCH_HMS: fld_ok = &eq[2:0];
         MATCH_ALL: fld_ok = &eq;
         default:   fld_ok = 1'b1;
      endcase
   end

   assign hit_o = tick_i & fld_ok;

endmodule

// File: rtl/alrm_regfile.sv
module alrm_regfile
   import alrm_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int ALM_BASE = 0,
   parameter int EN_ADDR  = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [BYTE_W-1:0]               wdata_i,
   output logic [N_FIELDS-1:0][BYTE_W-1:0] alm_o,
   output logic [EN_W-1:0]                 en_o
);

   if (BYTE_W < EN_W) begin : g_bad_width
      $error("alrm_regfile: BYTE_W too small for enable byte");
   end

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_alm
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALM_BASE + g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alm_o[g] <= '0;
         else if (wr_i && addr_i == MY_ADDR)
            alm_o[g] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_o <= '0;
      else if (wr_i && addr_i == ADDR_W'(EN_ADDR))
         en_o <= wdata_i[EN_W-1:0];
   end

endmodule

// File: rtl/alrm_flags.sv
module alrm_flags
   import alrm_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_i,
   input  logic            kick_i,
   input  logic            wdog_i,
   input  logic            wr_i,
   input  logic [2:0]      wbits_i,   // {tdf, ksf, wdf} write values
   input  logic            rd_i,
   input  logic [EN_W-1:0] en_i,
   output logic            tdf_o,
   output logic            ksf_o,
   output logic            wdf_o,
   output logic            irqf_o
);

   logic rd_q;
   logic rd_end;
   logic tdf_d, ksf_d, wdf_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_i;
   end

   assign rd_end = rd_q & ~rd_i;

   always_comb begin
      tdf_d = tdf_o;
      ksf_d = ksf_o;
      wdf_d = wdf_o;
      if (rd_end) begin
         tdf_d = 1'b0;
         ksf_d = 1'b0;
         wdf_d = 1'b0;
      end
      if (wr_i) begin
         tdf_d = tdf_d & wbits_i[2];
         ksf_d = wbits_i[1];
         wdf_d = wdf_d & wbits_i[0];
      end
      if (hit_i)  tdf_d = 1'b1;
      if (kick_i) ksf_d = 1'b1;
      if (wdog_i) wdf_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdf_o <= 1'b0;
         ksf_o <= 1'b0;
         wdf_o <= 1'b0;
      end else begin
         tdf_o <= tdf_d;
         ksf_o <= ksf_d;
         wdf_o <= wdf_d;
      end
   end

   assign irqf_o = (tdf_o & en_i[EN_TIE]) | (ksf_o & en_i[EN_KIE]) |
                   (wdf_o & en_i[EN_WDE]);

   a_r5_kick_recorded : assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> ksf_o);

   a_r6_wdog_recorded : assert property (@(posedge clk) disable iff (!rst_n)
      wdog_i |=> wdf_o);

   a_r8_hold_in_read : assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> (!$fell(tdf_o) && !$fell(ksf_o) && !$fell(wdf_o)));

   a_r9_event_beats_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !rd_i && hit_i) |=> tdf_o);

endmodule

// File: rtl/alrm_irq_unit.sv
module alrm_irq_unit
   import alrm_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int ALM_BASE  = 0,
   parameter int FLAG_ADDR = 4,
   parameter int EN_ADDR   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] time_sec_i,
   input  logic [BYTE_W-1:0] time_min_i,
   input  logic [BYTE_W-1:0] time_hour_i,
   input  logic [BYTE_W-1:0] time_wday_i,
   input  logic [BYTE_W-1:0] time_mday_i,
   input  logic              tick_i,
   input  logic              kick_i,
   input  logic              wdog_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [BYTE_W-1:0] bus_wdata_i,
   output logic [BYTE_W-1:0] bus_rdata_o,
   output logic [BYTE_W-1:0] flags_o,
   output logic              irq_n_o
);

   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam int ALM_LAST  = ALM_BASE + N_FIELDS - 1;

   if (ALM_LAST >= ADDR_SPAN || FLAG_ADDR >= ADDR_SPAN || EN_ADDR >= ADDR_SPAN)
   begin : g_bad_addr_range
      $error("alrm_irq_unit: register address outside ADDR_W space");
   end
   if (FLAG_ADDR == EN_ADDR ||
       (FLAG_ADDR >= ALM_BASE && FLAG_ADDR <= ALM_LAST) ||
       (EN_ADDR >= ALM_BASE && EN_ADDR <= ALM_LAST)) begin : g_bad_addr_overlap
      $error("alrm_irq_unit: register addresses overlap");
   end
   if (BYTE_W < 8) begin : g_bad_width
      $error("alrm_irq_unit: BYTE_W must be at least 8");
   end

   logic                            wr_acc, rd_acc, rd_flag;
   logic [N_FIELDS-1:0][BYTE_W-1:0] alm;
   logic [EN_W-1:0]                 en;
   logic                            hit;
   logic                            tdf, ksf, wdf, irqf;
   logic [ADDR_W-1:0]               alm_off;

   assign wr_acc  = bus_sel_i & bus_wr_i;
   assign rd_acc  = bus_sel_i & ~bus_wr_i;
   assign rd_flag = rd_acc & (bus_addr_i == ADDR_W'(FLAG_ADDR));

   alrm_regfile #(
      .BYTE_W   (BYTE_W),
      .ADDR_W   (ADDR_W),
      .ALM_BASE (ALM_BASE),
      .EN_ADDR  (EN_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_acc),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .alm_o   (alm),
      .en_o    (en)
   );

   alrm_match #(
      .BYTE_W (BYTE_W)
   ) u_match (
      .alm_i    (alm),
      .t_sec_i  (time_sec_i),
      .t_min_i  (time_min_i),
      .t_hour_i (time_hour_i),
      .t_wday_i (time_wday_i),
      .t_mday_i (time_mday_i),
      .tick_i   (tick_i),
      .hit_o    (hit)
   );

   alrm_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit),
      .kick_i  (kick_i),
      .wdog_i  (wdog_i),
      .wr_i    (wr_acc && bus_addr_i == ADDR_W'(FLAG_ADDR)),
      .wbits_i ({bus_wdata_i[FLG_TDF], bus_wdata_i[FLG_KSF], bus_wdata_i[FLG_WDF]}),
      .rd_i    (rd_flag),
      .en_i    (en),
      .tdf_o   (tdf),
      .ksf_o   (ksf),
      .wdf_o   (wdf),
      .irqf_o  (irqf)
   );

   always_comb begin
      flags_o          = '0;
      flags_o[FLG_TDF] = tdf;
      flags_o[FLG_KSF] = ksf;
      flags_o[FLG_WDF] = wdf;
      flags_o[FLG_IRQ] = irqf;
   end

   assign irq_n_o = ~irqf;
   assign alm_off = bus_addr_i - ADDR_W'(ALM_BASE);

   always_comb begin
      bus_rdata_o = '0;
      if (rd_acc) begin
         if (bus_addr_i == ADDR_W'(FLAG_ADDR))
            bus_rdata_o = flags_o;
         else if (bus_addr_i == ADDR_W'(EN_ADDR))
            bus_rdata_o = BYTE_W'(en);
         else if (alm_off < ADDR_W'(N_FIELDS))
            bus_rdata_o = alm[alm_off[1:0]];
      end
   end

   a_r4_alarm_needs_tick : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdf) |-> $past(tick_i));

   a_r7_irq_on_enabled_alarm : assert property (@(posedge clk) disable iff (!rst_n)
      (tdf && en[EN_TIE]) |-> !irq_n_o);

   a_r7_irq_idle_no_flags : assert property (@(posedge clk) disable iff (!rst_n)
      (!tdf && !ksf && !wdf) |-> irq_n_o);

endmodule

// File: tb/tb_alrm_irq_unit.sv
`timescale 1ns/1ps
module tb_alrm_irq_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_wday = '0, t_mday = '0;
   logic       tick = 1'b0, kick = 1'b0, wdog = 1'b0;
   logic       sel = 1'b0, wr = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, flags;
   logic       irq_n;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   alrm_irq_unit dut (
      .clk (clk), .rst_n (rst_n),
      .time_sec_i (t_sec), .time_min_i (t_min), .time_hour_i (t_hour),
      .time_wday_i (t_wday), .time_mday_i (t_mday),
      .tick_i (tick), .kick_i (kick), .wdog_i (wdog),
      .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr),
      .bus_wdata_i (wdata), .bus_rdata_o (rdata),
      .flags_o (flags), .irq_n_o (irq_n)
   );

   // {al_sec, al_min, al_hr, al_dd, t_sec, t_min, t_hr, t_wday, t_mday, exp}
   localparam logic [72:0] VEC [13] = '{
      {8'h90, 8'h80, 8'h80, 8'h80, 8'h56, 8'h34, 8'h12, 8'h01, 8'h01, 1'b1},
      {8'h30, 8'h80, 8'h80, 8'h80, 8'h30, 8'h34, 8'h12, 8'h01, 8'h01, 1'b1},
      {8'h30, 8'h80, 8'h80, 8'h80, 8'h31, 8'h34, 8'h12, 8'h01, 8'h01, 1'b0},
      {8'h45, 8'h12, 8'h80, 8'h80, 8'h45, 8'h12, 8'h07, 8'h01, 8'h01, 1'b1},
      {8'h45, 8'h12, 8'h80, 8'h80, 8'h45, 8'h13, 8'h07, 8'h01, 8'h01, 1'b0},
      {8'h00, 8'h00, 8'h23, 8'h80, 8'h00, 8'h00, 8'h23, 8'h01, 8'h01, 1'b1},
      {8'h00, 8'h00, 8'h23, 8'h80, 8'h00, 8'h00, 8'h22, 8'h01, 8'h01, 1'b0},
      {8'h00, 8'h30, 8'h08, 8'h15, 8'h00, 8'h30, 8'h08, 8'h03, 8'h15, 1'b1},
      {8'h00, 8'h30, 8'h08, 8'h15, 8'h00, 8'h30, 8'h08, 8'h03, 8'h16, 1'b0},
      {8'h00, 8'h30, 8'h08, 8'h43, 8'h00, 8'h30, 8'h08, 8'h03, 8'h16, 1'b1},
      {8'h00, 8'h30, 8'h08, 8'h43, 8'h00, 8'h30, 8'h08, 8'h04, 8'h03, 1'b0},
      {8'h91, 8'h22, 8'h85, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1},
      {8'h11, 8'hA2, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic flag_read_clear();
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 3'd4;
      @(negedge clk);
      sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset flags", 32'(flags), 32'h0);
      check("R10 reset irq", 32'(irq_n), 32'h1);

      // vector table: alarm mask modes
      for (int i = 0; i < 13; i++) begin
         string tag;
         tag = (i < 7) ? "R1 vector" : ((i < 11) ? "R3 vector" : "R2 vector");
         for (int k = 0; k < 4; k++)
            bus_write(3'(k), VEC[i][72 - 8*k -: 8]);
         flag_read_clear();
         {t_sec, t_min, t_hour, t_wday, t_mday} = VEC[i][40:1];
         pulse_tick();
         check($sformatf("%s %0d", tag, i), 32'(flags[3]), 32'(VEC[i][0]));
      end

      // R4: no tick, no alarm (every-second mask)
      for (int k = 0; k < 4; k++) bus_write(3'(k), 8'h80);
      flag_read_clear();
      repeat (5) @(negedge clk);
      check("R4 no tick no flag", 32'(flags[3]), 32'h0);
      pulse_tick();
      check("R4 tick sets flag", 32'(flags[3]), 32'h1);

      // R7: gating by enable
      check("R7 irq high, alarm disabled", 32'(irq_n), 32'h1);
      check("R7 irqf bit clear", 32'(flags[0]), 32'h0);
      bus_write(3'd5, 8'h04);
      check("R7 irq low, alarm enabled", 32'(irq_n), 32'h0);
      check("R7 irqf bit set", 32'(flags[0]), 32'h1);

      // R8: hold during read, clear on address change
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 3'd4;
      @(negedge clk);
      check("R8 read data alarm bit", 32'(rdata[3]), 32'h1);
      @(negedge clk);
      check("R8 flag held in read", 32'(flags[3]), 32'h1);
      addr = 3'd0;
      @(negedge clk);
      check("R8 cleared on addr change", 32'(flags[3]), 32'h0);
      check("R8 irq released", 32'(irq_n), 32'h1);
      sel = 1'b0;

      // R5: wake flag
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      check("R5 kick sets flag", 32'(flags[2]), 32'h1);
      check("R7 wake disabled irq high", 32'(irq_n), 32'h1);
      bus_write(3'd5, 8'h06);
      check("R7 wake enabled irq low", 32'(irq_n), 32'h0);
      bus_write(3'd4, 8'h00);
      check("R5 write 0 clears", 32'(flags[2]), 32'h0);
      bus_write(3'd4, 8'h04);
      check("R5 write 1 sets", 32'(flags[2]), 32'h1);
      flag_read_clear();
      check("R8 cleared on deselect", 32'(flags[3:1]), 32'h0);

      // R6: watchdog and alarm write semantics
      @(negedge clk); wdog = 1'b1;
      @(negedge clk); wdog = 1'b0;
      check("R6 wdog sets flag", 32'(flags[1]), 32'h1);
      bus_write(3'd5, 8'h01);
      check("R7 watchdog enabled irq low", 32'(irq_n), 32'h0);
      bus_write(3'd4, 8'h0A);
      check("R6 write 1 keeps wdog", 32'(flags[1]), 32'h1);
      check("R6 write 1 does not set alarm", 32'(flags[3]), 32'h0);
      bus_write(3'd4, 8'h00);
      check("R6 write 0 clears wdog", 32'(flags[1]), 32'h0);
      pulse_tick();
      check("R6 alarm set by tick", 32'(flags[3]), 32'h1);
      bus_write(3'd4, 8'h08);
      check("R6 write 1 keeps alarm", 32'(flags[3]), 32'h1);
      bus_write(3'd4, 8'h00);
      check("R6 write 0 clears alarm", 32'(flags[3]), 32'h0);

      // R9: events coincident with end-of-read clear
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 3'd4;
      @(negedge clk);
      sel = 1'b0; kick = 1'b1; tick = 1'b1;
      @(negedge clk);
      kick = 1'b0; tick = 1'b0;
      check("R9 wake survives clear", 32'(flags[2]), 32'h1);
      check("R9 alarm survives clear", 32'(flags[3]), 32'h1);
      @(negedge clk);
      check("R9 wake still set", 32'(flags[2]), 32'h1);

      // R10: upper bits
      bus_write(3'd4, 8'hF0);
      check("R10 upper bits zero", 32'(flags[7:4]), 32'h0);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 3'd4;
      @(negedge clk);
      check("R10 read upper zero", 32'(rdata[7:4]), 32'h0);
      sel = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule